// File: doc/BRIEF.md
# Linked-list DMA chain walker

The walker follows a chain of command blocks held in system memory and streams their payload words, in order, to a drawing-command consumer. Each block begins with one header word that carries the number of payload words after it and the byte address of the next header. After a start strobe the walker reads a header, fetches the payload words that follow it, then moves to the next header, and repeats until it meets a next address whose end flag is set.

While it walks, the walker adds up an estimated cost for the whole chain: a fixed overhead per node plus the node's payload length. A circular chain would never reach an end flag, so a guard counts visited nodes. Once a set number of nodes has been visited, every further header is written back with its end flag set. A circular chain then ends when the walk comes back to a header it has flagged. Before the walk reports completion, the guard walks the flagged headers again and restores them.

The consumer side uses a ready/valid handshake. The memory side is a single synchronous port with one cycle of read latency, shared by header reads, payload reads, flag writes and restore writes.

Top module: `chain_walker`

## Requirements
- R1: A start strobe seen while idle is accepted: the start address is latched and busy is high in the following cycle. A start strobe seen while busy is ignored and does not change the stream, the cost or the end of the walk.
- R2: If bit 23 of the start address is set, the walk ends without any memory access and without output words, with a cost of zero.
- R3: A header or payload word is fetched from word index = address bits [20:2]. Address bits 22..21 are ignored, so the payload and the next pointers wrap within a 2 MB space.
- R4: A header word holds the payload word count in bits [31:24] and the next address in bits [23:0]. The payload words occupy the word indices directly after the header and are forwarded in that order. A count of zero forwards nothing and moves straight to the next address.
- R5: The walk ends after the node whose next address has bit 23 set. That node's payload is still forwarded.
- R6: When the walk ends, the cost output equals the sum over all visited nodes of 5 plus the node's payload count.
- R7: An output word stays valid and unchanged until it is accepted (valid and ready high at one clock edge). No payload read is issued while the output holds a word that has not been accepted.
- R8: Nodes are numbered from 0 in visit order. From node number LOOP_LIMIT onward, every header whose bit 23 is clear is rewritten with bit 23 set, so a circular chain ends when it revisits a rewritten header.
- R9: Before completion, every rewritten header is restored to its original value. No other memory word, including a genuine end marker, is changed.
- R10: Done is a one-cycle pulse issued after the last payload word has been accepted, and busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_addr_i | input | 24 | Byte address of the first header; bit 23 set means an empty chain |
| mem_req_o | output | 1 | Memory access request for this cycle |
| mem_we_o | output | 1 | Access is a write (header rewrite) |
| mem_addr_o | output | MEM_AW-2 | Word index of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid in the cycle after a read request |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the output word |
| out_data_o | output | 32 | Forwarded payload word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cost_o | output | COST_W | Accumulated cost of the current or last walk |

## Verification
The hand-over of the final payload word and the completion pulse can fall on adjacent edges: the word's acceptance and the decision to finish are taken in the same cycle. The bench drives the consumer's ready with several patterns (always ready, pseudo-random, alternating and one cycle in four), so the last word is sometimes accepted at once and sometimes held for several cycles while the walker has nothing left to fetch. Each run is judged by comparing the full received stream against a stream computed from the memory image, and by checking that done appears exactly once, with busy low and no word still pending on the output.

// File: rtl/chain_walk_pkg.sv
// Package: chain_walk_pkg
// Shared constants and the state type of the linked-list chain walker.
// Assumes 32-bit memory words and the header layout {count[7:0], next[23:0]}.
package chain_walk_pkg;

    localparam int WORD_W        = 32;
    localparam int PTR_W         = 24;
    localparam int CNT_W         = 8;
    localparam int END_BIT       = 23;
    localparam int NODE_OVERHEAD = 5;
    localparam logic [WORD_W-1:0] END_MASK = WORD_W'(1) << END_BIT;

    typedef enum logic [3:0] {
        S_IDLE,   // waiting for a start strobe
        S_NEXT,   // test end flag, issue header read
        S_HDR,    // header data returns
        S_MARK,   // write header back with end flag set
        S_PAY,    // issue payload read when output is free
        S_PAYW,   // payload data returns into the output stage
        S_END,    // walk finished, decide on restore pass
        S_CLRR,   // restore pass: read a flagged header
        S_CLRW,   // restore pass: write it back cleared
        S_DRAIN   // wait for the last word to leave
    } walk_state_e;

endpackage

// File: rtl/chain_out_stage.sv
// Module: chain_out_stage
// One-entry output register with a ready/valid handshake. A word is loaded
// only when the stage is free; the caller must check free_o before issuing
// the read whose data will be loaded.
module chain_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         free_o
);

    logic         valid_q;
    logic [W-1:0] data_q;

    // Hold the word until the consumer takes it; accept a new one when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            data_q  <= load_data_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign free_o  = !valid_q || ready_i;

    // R7: a stalled word stays valid and unchanged
    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));

    // R7: a load never lands on a word that is still pending
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_q);

endmodule

// File: rtl/chain_cost_acc.sv
// Module: chain_cost_acc
// Accumulates the estimated cost of a walk: a fixed overhead per node plus
// the node's payload count. Cleared when a new walk starts.
module chain_cost_acc
    import chain_walk_pkg::*;
#(
    parameter int COST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic [COST_W-1:0] cost_o
);

    logic [COST_W-1:0] cost_q;

    // Restart on a new walk; add overhead plus length for each header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost_q <= '0;
        end else if (clear_i) begin
            cost_q <= '0;
        end else if (add_i) begin
            cost_q <= cost_q + COST_W'(len_i) + COST_W'(NODE_OVERHEAD);
        end
    end

    assign cost_o = cost_q;

    // R6: within a walk the cost never decreases
    p_cost_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (cost_q >= $past(cost_q)));

endmodule

// File: rtl/chain_loop_guard.sv
// Module: chain_loop_guard
// Counts visited nodes (saturating at LOOP_LIMIT). From node LOOP_LIMIT on,
// each header whose end flag is clear must be rewritten with the flag set;
// the guard requests that, counts the rewritten headers and keeps the word
// index of the first one for the restore pass. Assumes rewritten headers
// are visited consecutively, which holds because a flagged header ends the walk.
module chain_loop_guard #(
    parameter int LOOP_LIMIT = 8192,
    parameter int WIDX_W     = 19,
    parameter int MARK_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              node_i,
    input  logic              node_flag_i,
    input  logic [WIDX_W-1:0] node_idx_i,
    output logic              mark_o,
    output logic [WIDX_W-1:0] first_idx_o,
    output logic [MARK_W-1:0] mark_cnt_o
);

    localparam int IDX_W = $clog2(LOOP_LIMIT + 1);
    localparam logic [IDX_W-1:0] LIMIT_V = IDX_W'(LOOP_LIMIT);

    logic [IDX_W-1:0]  visits_q;
    logic [MARK_W-1:0] mark_cnt_q;
    logic [WIDX_W-1:0] first_idx_q;
    logic              at_limit;

    assign at_limit = (visits_q == LIMIT_V);
    assign mark_o   = node_i && at_limit && !node_flag_i;

    // Count visited nodes up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            visits_q <= '0;
        end else if (node_i && !at_limit) begin
            visits_q <= visits_q + IDX_W'(1);
        end
    end

    // Track how many headers were rewritten and where the first one is.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            mark_cnt_q  <= '0;
            first_idx_q <= '0;
        end else if (mark_o) begin
            mark_cnt_q <= mark_cnt_q + MARK_W'(1);
            if (mark_cnt_q == '0) begin
                first_idx_q <= node_idx_i;
            end
        end
    end

    assign first_idx_o = first_idx_q;
    assign mark_cnt_o  = mark_cnt_q;

    // R8: the rewrite count only grows during a walk
    p_marks_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (mark_cnt_q >= $past(mark_cnt_q)));

endmodule

// File: rtl/chain_walker.sv
// Module: chain_walker
// Walks a linked list of command blocks in memory and streams payload words.
// Header word: {count[31:24], next[23:0]}; next bit 23 set ends the chain.
// Memory is one synchronous port, read data one cycle after the request,
// word index = address bits [MEM_AW-1:2] (wraps inside 2**MEM_AW bytes).
// Assumes MEM_AW <= 22 and that the memory is not changed by others mid-walk.
module chain_walker
    import chain_walk_pkg::*;
#(
    parameter int MEM_AW     = 21,
    parameter int COST_W     = 32,
    parameter int LOOP_LIMIT = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PTR_W-1:0]    start_addr_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [MEM_AW-3:0]   mem_addr_o,
    output logic [WORD_W-1:0]   mem_wdata_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic [WORD_W-1:0]   out_data_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [COST_W-1:0]   cost_o
);

    localparam int WIDX_W = MEM_AW - 2;
    localparam int MARK_W = WIDX_W + 1;

    walk_state_e       state_q;
    logic              cur_end_q;
    logic [WIDX_W-1:0] cur_idx_q;
    logic [WORD_W-1:0] hdr_q;
    logic [WIDX_W-1:0] pay_idx_q;
    logic [CNT_W-1:0]  left_q;
    logic [WIDX_W-1:0] clr_idx_q;
    logic [MARK_W-1:0] clr_left_q;
    logic              done_q;

    logic              out_free;
    logic              walk_start;
    logic              hdr_phase;
    logic              mark_now;
    logic [WIDX_W-1:0] first_idx;
    logic [MARK_W-1:0] mark_cnt;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{start_addr_i[PTR_W-2:MEM_AW], start_addr_i[1:0]};
    assign walk_start = (state_q == S_IDLE) && start_i;
    assign hdr_phase  = (state_q == S_HDR);

    chain_out_stage #(.W(WORD_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (state_q == S_PAYW),
        .load_data_i (mem_rdata_i),
        .ready_i     (out_ready_i),
        .valid_o     (out_valid_o),
        .data_o      (out_data_o),
        .free_o      (out_free)
    );

    chain_cost_acc #(.COST_W(COST_W)) u_cost (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (walk_start),
        .add_i   (hdr_phase),
        .len_i   (mem_rdata_i[WORD_W-1 -: CNT_W]),
        .cost_o  (cost_o)
    );

    chain_loop_guard #(
        .LOOP_LIMIT (LOOP_LIMIT),
        .WIDX_W     (WIDX_W),
        .MARK_W     (MARK_W)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (walk_start),
        .node_i      (hdr_phase),
        .node_flag_i (mem_rdata_i[END_BIT]),
        .node_idx_i  (cur_idx_q),
        .mark_o      (mark_now),
        .first_idx_o (first_idx),
        .mark_cnt_o  (mark_cnt)
    );

    // Drive the single memory port from the current state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_idx_q;
        mem_wdata_o = '0;
        case (state_q)
            S_NEXT: begin
                mem_req_o = !cur_end_q;
            end
            S_MARK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = hdr_q | END_MASK;
            end
            S_PAY: begin
                mem_req_o  = (left_q != '0) && out_free;
                mem_addr_o = pay_idx_q;
            end
            S_CLRR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = clr_idx_q;
            end
            S_CLRW: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = clr_idx_q;
                mem_wdata_o = mem_rdata_i & ~END_MASK;
            end
            default: begin
                mem_req_o = 1'b0;
            end
        endcase
    end

    // Walk sequencer: header, optional rewrite, payload, next pointer, restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cur_end_q  <= 1'b0;
            cur_idx_q  <= '0;
            hdr_q      <= '0;
            pay_idx_q  <= '0;
            left_q     <= '0;
            clr_idx_q  <= '0;
            clr_left_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        cur_end_q <= start_addr_i[END_BIT];
                        cur_idx_q <= start_addr_i[MEM_AW-1:2];
                        state_q   <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    state_q <= cur_end_q ? S_END : S_HDR;
                end
                S_HDR: begin
                    hdr_q     <= mem_rdata_i;
                    left_q    <= mem_rdata_i[WORD_W-1 -: CNT_W];
                    pay_idx_q <= cur_idx_q + WIDX_W'(1);
                    state_q   <= mark_now ? S_MARK : S_PAY;
                end
                S_MARK: begin
                    state_q <= S_PAY;
                end
                S_PAY: begin
                    if (left_q == '0) begin
                        cur_end_q <= hdr_q[END_BIT];
                        cur_idx_q <= hdr_q[MEM_AW-1:2];
                        state_q   <= S_NEXT;
                    end else if (out_free) begin
                        pay_idx_q <= pay_idx_q + WIDX_W'(1);
                        left_q    <= left_q - CNT_W'(1);
                        state_q   <= S_PAYW;
                    end
                end
                S_PAYW: begin
                    state_q <= S_PAY;
                end
                S_END: begin
                    if (mark_cnt != '0) begin
                        clr_idx_q  <= first_idx;
                        clr_left_q <= mark_cnt;
                        state_q    <= S_CLRR;
                    end else begin
                        state_q <= S_DRAIN;
                    end
                end
                S_CLRR: begin
                    state_q <= S_CLRW;
                end
                S_CLRW: begin
                    clr_idx_q  <= mem_rdata_i[MEM_AW-1:2];
                    clr_left_q <= clr_left_q - MARK_W'(1);
                    state_q    <= (clr_left_q == MARK_W'(1)) ? S_DRAIN : S_CLRR;
                end
                S_DRAIN: begin
                    if (out_free) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign done_o = done_q;

    // R2: an idle walker leaves the memory port alone
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    // R10: done is raised only with busy already low
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10: done lasts exactly one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: nothing is left on the output when done is raised
    p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid_o);

endmodule

// File: tb/test_chain_walker.sv
// Bench for chain_walker: builds chains in a sparse memory model, computes
// the expected stream, cost and final memory image, and compares.
module test_chain_walker;

    localparam int MEM_AW = 21;
    localparam int COST_W = 32;
    localparam int LIMIT  = 6;
    localparam int WIDX_W = MEM_AW - 2;
    localparam int unsigned IDX_MASK = 32'h0007_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [23:0]       start_addr_i = '0;
    logic              mem_req_o;
    logic              mem_we_o;
    logic [WIDX_W-1:0] mem_addr_o;
    logic [31:0]       mem_wdata_o;
    logic [31:0]       mem_rdata_i = '0;
    logic              out_valid_o;
    logic              out_ready_i = 1'b0;
    logic [31:0]       out_data_o;
    logic              busy_o;
    logic              done_o;
    logic [COST_W-1:0] cost_o;

    always #2 clk = ~clk;

    chain_walker #(
        .MEM_AW     (MEM_AW),
        .COST_W     (COST_W),
        .LOOP_LIMIT (LIMIT)
    ) i_chain_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .out_valid_o  (out_valid_o),
        .out_ready_i  (out_ready_i),
        .out_data_o   (out_data_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .cost_o       (cost_o)
    );

    logic [31:0] mem  [int unsigned];
    logic [31:0] orig [int unsigned];
    logic [31:0] got_q [$];
    logic [31:0] exp_q [$];
    longint      exp_cost;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          mem_reads = 0;
    int          done_seen = 0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Synchronous memory: read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) begin
                mem[int'(mem_addr_o)] = mem_wdata_o;
            end else begin
                mem_reads++;
                mem_rdata_i <= rd(int'(mem_addr_o));
            end
        end
    end

    // Consumer, output monitor and watchdog, all away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0:       out_ready_i = 1'b1;
            1:       out_ready_i = lfsr[0];
            2:       out_ready_i = cyc[0];
            default: out_ready_i = (cyc[1:0] == 2'b00);
        endcase
        #1;
        if (prev_stall) begin
            chk(out_valid_o && (out_data_o == prev_data), "R7", "stalled word held",
                longint'(out_data_o), longint'(prev_data));
        end
        if (out_valid_o && out_ready_i) got_q.push_back(out_data_o);
        if (done_o) begin
            done_seen++;
            chk(!busy_o, "R10", "busy low with done", longint'(busy_o), 0);
            chk(!out_valid_o, "R10", "no pending word at done", longint'(out_valid_o), 0);
            if (prev_done) chk(1'b0, "R10", "done wider than one cycle", 2, 1);
        end
        prev_stall = out_valid_o && !out_ready_i;
        prev_data  = out_data_o;
        prev_done  = done_o;
        if (cyc > 190000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic put_node(input logic [23:0] a, input int n, input logic [23:0] nxt,
                            input int seed);
        int unsigned hi;
        hi = int'(a[20:2]);
        mem[hi] = {8'(n), nxt};
        for (int i = 0; i < n; i++) begin
            mem[(hi + 1 + i) & IDX_MASK] = 32'hA500_0000 ^ (32'(seed) << 8) ^ 32'(i);
        end
    endtask

    // Expected stream and cost from the requirements, on a private copy.
    task automatic model(input logic [23:0] sa);
        logic [31:0] mm [int unsigned];
        logic [23:0] a;
        logic [31:0] h;
        int unsigned hi;
        int          n;
        int          k;
        mm = mem;
        a = sa;
        k = 0;
        exp_cost = 0;
        exp_q.delete();
        while (!a[23] && k < 20000) begin
            hi = int'(a[20:2]);
            h  = mm.exists(hi) ? mm[hi] : 32'h0;
            n  = int'(h[31:24]);
            for (int i = 0; i < n; i++) begin
                exp_q.push_back(mm.exists((hi + 1 + i) & IDX_MASK) ?
                                mm[(hi + 1 + i) & IDX_MASK] : 32'h0);
            end
            exp_cost += 5 + n;
            if (k >= LIMIT && !h[23]) mm[hi] = h | 32'h0080_0000;
            a = h[23:0];
            k++;
        end
    endtask

    task automatic run_walk(input logic [23:0] sa, input int rmode, input bit inject,
                            input string tag);
        int bad;
        int reads0;
        int t0;
        ready_mode = rmode;
        model(sa);
        orig = mem;
        got_q.delete();
        done_seen = 0;
        reads0 = mem_reads;
        @(negedge clk);
        start_i = 1'b1;
        start_addr_i = sa;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R1", {tag, " busy after start"}, longint'(busy_o), 1);
        if (inject) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            start_addr_i = 24'h000100;
            @(negedge clk);
            start_i = 1'b0;
        end
        t0 = cyc;
        while (done_seen == 0 && cyc - t0 < 20000) @(negedge clk);
        @(negedge clk);
        #2;
        chk(done_seen == 1, "R10", {tag, " done pulses"}, done_seen, 1);
        chk(got_q.size() == exp_q.size(), "R4", {tag, " word count"},
            got_q.size(), exp_q.size());
        bad = 0;
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            if (got_q[i] !== exp_q[i]) bad++;
        end
        chk(bad == 0, "R5", {tag, " stream order and content"}, bad, 0);
        chk(longint'(cost_o) == exp_cost, "R6", {tag, " cost"}, longint'(cost_o), exp_cost);
        bad = 0;
        foreach (orig[k]) begin
            if (!mem.exists(k) || mem[k] !== orig[k]) bad++;
        end
        chk(bad == 0 && mem.num() == orig.num(), "R9", {tag, " memory restored"}, bad, 0);
        if (sa[23]) begin
            chk(mem_reads == reads0, "R2", {tag, " no memory reads"}, mem_reads - reads0, 0);
        end
    endtask

    initial begin
        logic [23:0] base;
        logic [23:0] nx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy_o && !done_o && !out_valid_o && !mem_req_o && cost_o == '0, "R10",
            "reset state", longint'({busy_o, done_o, out_valid_o, mem_req_o}), 0);

        // R2: empty chain
        mem.delete();
        run_walk(24'h800000, 0, 1'b0, "R2 empty");
        run_walk(24'hFFFFFF, 1, 1'b0, "R2 empty all ones");

        // R4 R5 R6: sweep chain length, payload lengths (zero included) and ready
        for (int n = 1; n <= 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                mem.delete();
                base = 24'(32'h1000 * (n * 4 + m));
                for (int j = 0; j < n; j++) begin
                    nx = (j == n - 1) ? ((m % 2 == 1) ? 24'h8ABCDE : 24'hFFFFFF)
                                      : base + 24'(32'h40 * (j + 1));
                    put_node(base + 24'(32'h40 * j), (n + 2 * j + m) % 6, nx, n * 16 + j);
                end
                run_walk(base, m, 1'b0, "R4 sweep");
            end
        end

        // R3: payload wraps at the top of the 2 MB space, upper pointer bits ignored
        mem.delete();
        put_node(24'h1FFFF8, 3, 24'h3FFF00, 7);
        put_node(24'h1FFF00, 1, 24'hFFFFFF, 8);
        run_walk(24'h7FFFF8, 1, 1'b0, "R3 wrap");

        // R8 R9: long terminated chain past the limit keeps its end marker
        mem.delete();
        for (int j = 0; j < LIMIT + 4; j++) begin
            nx = (j == LIMIT + 3) ? 24'hFFFFFF : 24'(32'h2000 + 32'h20 * (j + 1));
            put_node(24'(32'h2000 + 32'h20 * j), j % 3, nx, 40 + j);
        end
        run_walk(24'h002000, 1, 1'b0, "R9 long chain");

        // R8: three-node ring
        mem.delete();
        put_node(24'h003000, 2, 24'h003100, 50);
        put_node(24'h003100, 0, 24'h003200, 51);
        put_node(24'h003200, 1, 24'h003000, 52);
        run_walk(24'h003000, 2, 1'b0, "R8 ring of three");

        // R8: self-loop with empty payload
        mem.delete();
        put_node(24'h004000, 0, 24'h004000, 60);
        run_walk(24'h004000, 0, 1'b0, "R8 self loop");

        // R8: ring entered after a lead-in
        mem.delete();
        put_node(24'h005000, 1, 24'h005100, 70);
        put_node(24'h005100, 2, 24'h005200, 71);
        put_node(24'h005200, 3, 24'h005300, 72);
        put_node(24'h005300, 1, 24'h005200, 73);
        run_walk(24'h005000, 3, 1'b0, "R8 lead-in ring");

        // R1: a second start while busy is ignored
        mem.delete();
        put_node(24'h000100, 2, 24'hFFFFFF, 90);
        for (int j = 0; j < 4; j++) begin
            nx = (j == 3) ? 24'hFFFFFF : 24'(32'h6000 + 32'h40 * (j + 1));
            put_node(24'(32'h6000 + 32'h40 * j), 5, nx, 80 + j);
        end
        run_walk(24'h006000, 3, 1'b1, "R1 start while busy");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule